// File: doc/BRIEF.md
# Half-Word Immediate Shift Execution Unit

This unit holds a file of eight 32-bit registers. It executes one operation per cycle: a 16-bit half of a source register is shifted by a signed 5-bit immediate count, and the result is written into a chosen half of a destination register. The other half of the destination is carried over unchanged. A read-modify-write path reads the old destination word and merges the new half into it.

Operations are presented on a valid strobe together with their fields. The register file updates on the next rising clock edge, so a following operation always sees the result of the one before it. A separate load command writes a whole 32-bit word into one register, and it wins over a shift that arrives in the same cycle. A combinational read port exposes any register so that its contents can be checked.

Top module: `hsu_top`

## Requirements
- R1: A synchronous active-high `rst` clears all eight registers to 0x00000000 at the next rising edge.
- R2: With `ld_valid` high, `ld_data` is written whole into register `ld_idx` at the next rising edge. `rd_data` shows register `rd_idx` combinationally.
- R3: When `ld_valid` and `op_valid` are both high in one cycle, only the load takes effect and the shift is discarded.
- R4: The operand is bits [15:0] of register `op_src` when `op_src_hi` is 0, and bits [31:16] when it is 1.
- R5: The result goes into bits [15:0] of `op_dst` when `op_dst_hi` is 0, and into bits [31:16] when it is 1. The other 16 bits of `op_dst` keep their value.
- R6: A count from 1 to 15 (`op_cnt[4]`=0) shifts left. Vacated bits are filled with zeros and bits above bit 15 are lost, with no saturation and no protection of the sign bit. Examples: 0x0107 by 7 gives 0x8380, 0x0001 by 15 gives 0x8000, and 0x0003 by 14 gives 0xC000.
- R7: A count of 0 writes the operand unchanged.
- R8: A count from -1 to -16 (two's complement, `op_cnt[4]`=1) is an arithmetic right shift by the magnitude. Bit 15 is replicated, so a count of -16 gives 0xFFFF or 0x0000 depending on the sign of the operand.
- R9: Source and destination may be the same register and the same half. An operation reads the value left by every earlier operation, including one issued in the previous cycle.
- R10: In a cycle with both `op_valid` and `ld_valid` low, no register changes, whatever the operation fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Shift operation present this cycle |
| op_src | input | 3 | Source register index |
| op_src_hi | input | 1 | 1 selects the upper source half |
| op_dst | input | 3 | Destination register index |
| op_dst_hi | input | 1 | 1 selects the upper destination half |
| op_cnt | input | 5 | Signed shift count, positive means left |
| ld_valid | input | 1 | Whole-register load this cycle |
| ld_idx | input | 3 | Load target register |
| ld_data | input | 32 | Load value |
| rd_idx | input | 3 | Read port register index |
| rd_data | output | 32 | Read port data |

## Verification
The assertions assume that `rst` is asserted before any operation is issued, so the register contents are known when the shift and merge checks start. They also assume that the control strobes are never X while out of reset. The bench drives every input from a defined value at time zero and holds `rst` high for several cycles. It issues operations only at falling edges, so each strobe is stable across the rising edge that samples it. Counts are drawn only from the legal range -16 to 15, and the count field is always a complete two's-complement 5-bit value.

// File: rtl/hsu_pkg.sv
package hsu_pkg;
    typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} half_e;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/hsu_shifter.sv
module hsu_shifter #(
    parameter int unsigned HALF = 16,
    parameter int unsigned CNTW = 5
) (
    input  logic [HALF-1:0] opnd,
    input  logic [CNTW-1:0] cnt,
    output logic [HALF-1:0] res
);
    logic            go_right;
    logic [CNTW-1:0] mag;

    always_comb begin
        go_right = cnt[CNTW-1];
        mag      = go_right ? (~cnt + 1'b1) : cnt;
        if (go_right) begin
            res = $unsigned($signed(opnd) >>> mag);
        end else begin
            res = opnd << mag;
        end
    end
endmodule

// File: rtl/hsu_merge.sv
module hsu_merge #(
    parameter int unsigned WORD = 32
) (
    input  logic [WORD-1:0]   old_word,
    input  logic [WORD/2-1:0] new_half,
    input  logic              put_hi,
    output logic [WORD-1:0]   merged
);
    localparam int unsigned HALF = WORD / 2;

    always_comb begin
        merged = old_word;
        if (put_hi == hsu_pkg::HALF_HI) begin
            merged[WORD-1:HALF] = new_half;
        end else begin
            merged[HALF-1:0] = new_half;
        end
    end
endmodule

// File: rtl/hsu_regfile.sv
module hsu_regfile #(
    parameter int unsigned NREG = 8,
    parameter int unsigned WORD = 32,
    parameter int unsigned NRD  = 3,
    localparam int unsigned IDXW = hsu_pkg::idx_bits(NREG)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDXW-1:0]           wr_idx,
    input  logic [WORD-1:0]           wr_data,
    input  logic [NRD-1:0][IDXW-1:0]  rd_idx,
    output logic [NRD-1:0][WORD-1:0]  rd_data
);
    typedef struct packed {
        logic [NREG-1:0][WORD-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.regs = '0;
        end else if (wr_en) begin
            st_d.regs[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    for (genvar gr = 0; gr < NRD; gr++) begin : g_rd
        assign rd_data[gr] = st_q.regs[rd_idx[gr]];
    end

    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> st_q.regs[$past(wr_idx)] == $past(wr_data));

    for (genvar gi = 0; gi < NREG; gi++) begin : g_chk
        p_reset_clear_r1: assert property (@(posedge clk)
            rst |=> st_q.regs[gi] == '0);
        p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
            !wr_en |=> $stable(st_q.regs[gi]));
    end
endmodule

// File: rtl/hsu_top.sv
module hsu_top #(
    parameter int unsigned NREG = 8,
    parameter int unsigned WORD = 32,
    parameter int unsigned CNTW = 5,
    localparam int unsigned HALF = WORD / 2,
    localparam int unsigned IDXW = hsu_pkg::idx_bits(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [IDXW-1:0] op_src,
    input  logic            op_src_hi,
    input  logic [IDXW-1:0] op_dst,
    input  logic            op_dst_hi,
    input  logic [CNTW-1:0] op_cnt,
    input  logic            ld_valid,
    input  logic [IDXW-1:0] ld_idx,
    input  logic [WORD-1:0] ld_data,
    input  logic [IDXW-1:0] rd_idx,
    output logic [WORD-1:0] rd_data
);
    localparam int unsigned NRD = 3;

    logic [NRD-1:0][IDXW-1:0] rf_rd_idx;
    logic [NRD-1:0][WORD-1:0] rf_rd_data;
    logic [WORD-1:0]          src_word, dst_word, merged;
    logic [HALF-1:0]          operand, shifted;
    logic                     shift_fire, wr_en;
    logic [IDXW-1:0]          wr_idx;
    logic [WORD-1:0]          wr_data;

    assign rf_rd_idx = {rd_idx, op_dst, op_src};
    assign src_word  = rf_rd_data[0];
    assign dst_word  = rf_rd_data[1];
    assign rd_data   = rf_rd_data[2];

    always_comb begin
        shift_fire = op_valid && !ld_valid;
        operand    = (op_src_hi == hsu_pkg::HALF_HI) ? src_word[WORD-1:HALF]
                                                     : src_word[HALF-1:0];
        wr_en      = ld_valid || op_valid;
        wr_idx     = ld_valid ? ld_idx  : op_dst;
        wr_data    = ld_valid ? ld_data : merged;
    end

    hsu_shifter #(.HALF(HALF), .CNTW(CNTW)) u_shift (
        .opnd (operand),
        .cnt  (op_cnt),
        .res  (shifted)
    );

    hsu_merge #(.WORD(WORD)) u_merge (
        .old_word (dst_word),
        .new_half (shifted),
        .put_hi   (op_dst_hi),
        .merged   (merged)
    );

    hsu_regfile #(.NREG(NREG), .WORD(WORD), .NRD(NRD)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rf_rd_idx),
        .rd_data (rf_rd_data)
    );

    p_zero_count_r7: assert property (@(posedge clk) disable iff (rst)
        shift_fire && op_cnt == '0 |-> shifted == operand);
    p_left_fill_r6: assert property (@(posedge clk) disable iff (rst)
        shift_fire && !op_cnt[CNTW-1] && op_cnt != '0 |-> shifted[0] == 1'b0);
    p_right_sign_r8: assert property (@(posedge clk) disable iff (rst)
        shift_fire && op_cnt[CNTW-1] |-> shifted[HALF-1] == operand[HALF-1]);
    p_keep_low_r5: assert property (@(posedge clk) disable iff (rst)
        shift_fire && op_dst_hi |-> wr_data[HALF-1:0] == dst_word[HALF-1:0]);
    p_keep_high_r5: assert property (@(posedge clk) disable iff (rst)
        shift_fire && !op_dst_hi |-> wr_data[WORD-1:HALF] == dst_word[WORD-1:HALF]);
    p_load_wins_r3: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> wr_idx == ld_idx && wr_data == ld_data);
endmodule

// File: tb/test_hsu_top.sv
`timescale 1ns/1ps
module test_hsu_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_src = '0;
    logic        op_src_hi = 1'b0;
    logic [2:0]  op_dst = '0;
    logic        op_dst_hi = 1'b0;
    logic [4:0]  op_cnt = '0;
    logic        ld_valid = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          idx;
        logic [31:0] val;
        string       req;
    } exp_t;
    exp_t sb[$];

    logic [31:0] model [8];

    always #5 clk = ~clk;

    hsu_top i_hsu_top (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_src(op_src),
        .op_src_hi(op_src_hi), .op_dst(op_dst), .op_dst_hi(op_dst_hi),
        .op_cnt(op_cnt), .ld_valid(ld_valid), .ld_idx(ld_idx),
        .ld_data(ld_data), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    function automatic logic [15:0] ref_shift(logic [15:0] v, int c);
        logic [31:0] ext;
        if (c >= 0) return 16'(v << c);
        ext = {{16{v[15]}}, v};
        return 16'(ext >> (-c));
    endfunction

    task automatic push(int idx, logic [31:0] val, string req);
        exp_t e;
        e.idx = idx; e.val = val; e.req = req;
        sb.push_back(e);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load(int idx, logic [31:0] val, string req);
        @(negedge clk);
        ld_valid = 1'b1; ld_idx = 3'(idx); ld_data = val;
        @(posedge clk); #1;
        ld_valid = 1'b0;
        model[idx] = val;
        push(idx, model[idx], req);
    endtask

    task automatic apply_model(int s, bit shi, int d, bit dhi, int c);
        logic [15:0] opv, r;
        opv = shi ? model[s][31:16] : model[s][15:0];
        r = ref_shift(opv, c);
        if (dhi) model[d][31:16] = r; else model[d][15:0] = r;
    endtask

    task automatic do_shift(int s, bit shi, int d, bit dhi, int c, string req);
        @(negedge clk);
        op_valid = 1'b1; op_src = 3'(s); op_src_hi = shi;
        op_dst = 3'(d); op_dst_hi = dhi; op_cnt = 5'(c);
        @(posedge clk); #1;
        op_valid = 1'b0;
        apply_model(s, shi, d, dhi, c);
        push(d, model[d], req);
    endtask

    task automatic do_both(int li, logic [31:0] lv, int s, int d, int c);
        @(negedge clk);
        ld_valid = 1'b1; ld_idx = 3'(li); ld_data = lv;
        op_valid = 1'b1; op_src = 3'(s); op_src_hi = 1'b0;
        op_dst = 3'(d); op_dst_hi = 1'b0; op_cnt = 5'(c);
        @(posedge clk); #1;
        ld_valid = 1'b0; op_valid = 1'b0;
        model[li] = lv;
        push(li, model[li], "R3");
        push(d, model[d], "R3");
    endtask

    task automatic do_nothing(int s, int d, int c);
        @(negedge clk);
        op_valid = 1'b0; op_src = 3'(s); op_dst = 3'(d);
        op_dst_hi = 1'b1; op_cnt = 5'(c);
        @(posedge clk); #1;
        push(d, model[d], "R10");
    endtask

    // monitor: pops expected items and compares at the read port
    initial begin
        forever begin
            @(negedge clk); #1;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                rd_idx = 3'(e.idx);
                #1;
                checks++;
                if (rd_data !== e.val) begin
                    errors++;
                    $display("FAIL %s reg %0d actual %h expected %h",
                             e.req, e.idx, rd_data, e.val);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R2: loads
        for (int i = 0; i < 8; i++) do_load(i, 32'h1111_0000 * (i + 1) + 32'(i * 3 + 5), "R2");
        idle(2);

        // R1: reset clears everything
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = '0;
        for (int i = 0; i < 8; i++) push(i, 32'h0, "R1");
        idle(3);

        // R6: left shifts with literal results
        do_load(7, 32'h0108_0107, "R2");
        do_shift(7, 0, 7, 0, 7, "R6");
        push(7, 32'h0108_8380, "R6");
        do_load(1, 32'h0000_0001, "R2");
        do_shift(1, 0, 1, 1, 15, "R6");
        push(1, 32'h8000_0001, "R6");
        do_load(2, 32'hA000_0003, "R2");
        do_shift(2, 0, 2, 1, 14, "R6");
        push(2, 32'hC000_0003, "R6");

        // R7: zero count
        do_load(3, 32'h5A5A_1234, "R2");
        do_shift(3, 0, 3, 1, 0, "R7");
        push(3, 32'h1234_1234, "R7");

        // R4: high source half into low destination half
        do_load(0, 32'h0A01_0000, "R2");
        do_load(4, 32'h0D03_0000, "R2");
        do_shift(0, 1, 4, 0, 12, "R4");
        push(4, 32'h0D03_1000, "R4");

        // R8: arithmetic right shifts
        do_load(5, 32'h1234_5678, "R2");
        do_load(6, 32'h7FFF_8010, "R2");
        do_shift(6, 0, 5, 1, -4, "R8");
        push(5, 32'hF801_5678, "R8");
        do_shift(6, 0, 5, 0, -16, "R8");
        push(5, 32'hF801_FFFF, "R8");
        do_shift(6, 1, 5, 0, -16, "R8");
        push(5, 32'hF801_0000, "R8");
        do_shift(6, 1, 5, 1, -1, "R8");
        push(5, 32'h3FFF_0000, "R8");

        // R5: upper half written, lower kept
        do_load(0, 32'hBEEF_00F0, "R2");
        do_shift(0, 0, 0, 1, 4, "R5");
        push(0, 32'h0F00_00F0, "R5");

        // R9: back-to-back chain, same register and half
        do_load(1, 32'h0001_0001, "R2");
        for (int i = 0; i < 6; i++) do_shift(1, 0, 1, 0, 1, "R9");
        push(1, 32'h0001_0040, "R9");
        for (int i = 0; i < 7; i++) do_shift(i, i[0], i + 1, ~i[0], 3, "R9");

        // R3: load and shift in one cycle
        do_both(2, 32'hCAFE_F00D, 3, 4, 2);
        do_both(6, 32'h0000_0001, 6, 6, 5);
        push(6, 32'h0000_0001, "R3");

        // R10: fields set, valid low
        do_nothing(0, 7, 3);
        do_nothing(7, 7, -2);

        // R5/R9: pseudo-random mix
        lfsr = 16'hACE1;
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            do_shift(int'(lfsr[2:0]), lfsr[3], int'(lfsr[6:4]), lfsr[7],
                     int'($signed(lfsr[12:8])), "R5");
        end

        idle(4);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule